// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Write-Back Data Cache

This block is a direct-mapped, write-back first-level data cache of 8 KiB with 32-byte lines and 4 KiB pages. Each access selects its set using virtual address bits 12:5, and bit 12 belongs to the virtual page number. While that set's tag and line are read, the cache sends the virtual page number to a small external TLB. The translated physical page number then goes to the tag compare. A hit returns load data, or merges store data into the line and marks it dirty.

The stored tag is the whole 20-bit physical page number, so it also covers the physical copy of the top index bit. A dirty victim's 27-bit physical line address is therefore formed from its stored tag plus index bits 6:0, which lie inside the page offset. No translation is needed at eviction time.

Misses use write-allocate. Any dirty victim goes out on the writeback channel first. The line is then fetched on the refill channel and the access is retried. If the TLB misses, the access completes with a fault indication and the cache is left untouched.

Top module: `vipt_dcache`

## Requirements
- R1: After reset `cpu_req_ready` is 1, and `cpu_resp_valid`, `wb_valid` and `rf_req_valid` are 0. Every line is invalid.
- R2: A load is a hit when the line at set `vaddr[12:5]` is valid and its tag equals `tlb_ppn`. For a hit, `cpu_resp_valid` rises two rising edges after the request is accepted. No writeback or refill request is raised.
- R3: The hit compare uses all 20 page-number bits. Two physical pages that differ only in their lowest page-number bit, reached through the same set, never hit each other's line.
- R4: During an access `tlb_vpn` equals `vaddr[31:12]`. If `tlb_hit` is 0, the response has `cpu_resp_fault`=1. No writeback or refill happens, and no line, tag, valid or dirty state changes.
- R5: On a miss the refill address is `{tlb_ppn, vaddr[11:5]}`. The returned line is installed clean with that tag. The access is then retried and answered from the installed line.
- R6: If the victim line is valid and dirty, its writeback completes before the refill request. `wb_addr` is `{stored tag, set[6:0]}`, and `wb_data` is the whole line as last written.
- R7: A clean or invalid victim causes no writeback. The refill request is raised directly.
- R8: A store hit merges its data into the line and marks the line dirty, with no next-level traffic. A word store writes `wdata` at word `vaddr[4:2]`. A byte store writes `wdata[7:0]` at byte `vaddr[4:0]`.
- R9: A store miss allocates the line: it writes back a dirty victim, refills, and then performs the store into the refilled line.
- R10: Line byte k sits in bits 8k+7:8k on the refill and writeback buses and in the array. A word load returns word `vaddr[4:2]` and ignores `vaddr[1:0]`. A byte load (`cpu_req_byte`=1) returns byte `vaddr[4:0]` zero-extended to 32 bits.
- R11: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_addr` and `wb_data` hold. While `rf_req_valid` is 1 and `rf_req_ready` is 0, `rf_req_valid` and `rf_req_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Access request |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_req_vaddr | input | 32 | Virtual byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_fault | output | 1 | Translation missing; access not performed |
| cpu_resp_rdata | output | 32 | Load data |
| tlb_vpn | output | 20 | Virtual page number to translate |
| tlb_hit | input | 1 | Translation found |
| tlb_ppn | input | 20 | Physical page number |
| wb_valid | output | 1 | Writeback line offered |
| wb_ready | input | 1 | Next level accepts the writeback |
| wb_addr | output | 27 | Physical line address of the victim |
| wb_data | output | 256 | Victim line |
| rf_req_valid | output | 1 | Refill request |
| rf_req_ready | input | 1 | Next level accepts the refill request |
| rf_req_addr | output | 27 | Physical line address to fetch |
| rf_resp_valid | input | 1 | Refill line present |
| rf_resp_data | input | 256 | Refill line |

## Verification
The assertions assume three things about the environment. First, the TLB gives the same answer for a page number for the whole of an access, including its retry after a refill. Second, `rf_resp_valid` is raised only after a refill request has been accepted. Third, no two virtual pages whose bit 12 differs are mapped onto the same physical page.

The bench's TLB holds a fixed table that is set before any request is made. Its next-level model answers a refill only after it has accepted the request. Every pair of mapped pages that share a set points at distinct physical pages.

// File: rtl/vipt_dcache_pkg.sv
package vipt_dcache_pkg;
  parameter int VA_W    = 32;
  parameter int PA_W    = 32;
  parameter int PG_W    = 12;
  parameter int LINE_B  = 32;
  parameter int CACHE_B = 8192;
  parameter int WORD_W  = 32;

  localparam int OFF_W     = $clog2(LINE_B);
  localparam int SETS      = CACHE_B / LINE_B;
  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = PA_W - PG_W;
  localparam int VPN_W     = VA_W - PG_W;
  localparam int LADDR_W   = PA_W - OFF_W;
  localparam int IN_PG_W   = PG_W - OFF_W;
  localparam int LINE_W    = LINE_B * 8;
  localparam int WSEL_W    = OFF_W - 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ACC, S_WB, S_RFQ, S_RFW
  } ctrl_state_t;

  // Physical line address from a full page number and the index bits below the page boundary.
  function automatic logic [LADDR_W-1:0] rebuild_line(input logic [TAG_W-1:0] page,
                                                      input logic [IN_PG_W-1:0] low_idx);
    return {page, low_idx};
  endfunction

  // Load lane: word select by offset[4:2]; byte loads zero-extended.
  function automatic logic [WORD_W-1:0] read_lane(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic is_byte);
    logic [WORD_W-1:0] w;
    w = line[{off[OFF_W-1:2], 5'b0} +: WORD_W];
    if (is_byte) return {{(WORD_W-8){1'b0}}, w[{off[1:0], 3'b0} +: 8]};
    return w;
  endfunction

  // Store merge into a line.
  function automatic logic [LINE_W-1:0] merge_line(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic is_byte,
                                                   input logic [WORD_W-1:0] wdata);
    logic [LINE_W-1:0] r;
    r = line;
    if (is_byte) r[{off, 3'b0} +: 8] = wdata[7:0];
    else         r[{off[OFF_W-1:2], 5'b0} +: WORD_W] = wdata;
    return r;
  endfunction
endpackage

// File: rtl/vipt_dcache_tags.sv
module vipt_dcache_tags
  import vipt_dcache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_we,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_we) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (dirty_set) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  // R5: an installed line is valid and clean
  assert_fill_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (rd_valid && !rd_dirty));

  // R8: a store hit leaves its line dirty
  assert_store_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_set |=> rd_dirty);
endmodule

// File: rtl/vipt_dcache_data.sv
module vipt_dcache_data
  import vipt_dcache_pkg::*;
(
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [LINE_W-1:0] wline,
  output logic [LINE_W-1:0] rline
);
  logic [LINE_W-1:0] mem_q [SETS];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wline;
  end

  assign rline = mem_q[idx];
endmodule

// File: rtl/vipt_dcache_ctrl.sv
module vipt_dcache_ctrl
  import vipt_dcache_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_store,
  input  logic               cpu_req_byte,
  input  logic [VA_W-1:0]    cpu_req_vaddr,
  input  logic [WORD_W-1:0]  cpu_req_wdata,
  output logic               cpu_resp_valid,
  output logic               cpu_resp_fault,
  output logic [WORD_W-1:0]  cpu_resp_rdata,
  output logic [VPN_W-1:0]   tlb_vpn,
  input  logic               tlb_hit,
  input  logic [TAG_W-1:0]   tlb_ppn,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [LADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0]  wb_data,
  output logic               rf_req_valid,
  input  logic               rf_req_ready,
  output logic [LADDR_W-1:0] rf_req_addr,
  input  logic               rf_resp_valid,
  input  logic [LINE_W-1:0]  rf_resp_data,
  output logic [IDX_W-1:0]   idx,
  input  logic               vic_valid,
  input  logic               vic_dirty,
  input  logic [TAG_W-1:0]   vic_tag,
  input  logic [LINE_W-1:0]  line_rd,
  output logic               fill_we,
  output logic [TAG_W-1:0]   fill_tag,
  output logic               dirty_set,
  output logic               data_we,
  output logic [LINE_W-1:0]  data_wline
);
  ctrl_state_t        st_q, st_d;
  logic [VA_W-1:0]    va_q;
  logic               store_q, byte_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [LADDR_W-1:0] fill_addr_q;
  logic               resp_valid_q, resp_fault_q;
  logic [WORD_W-1:0]  rdata_q;

  // Named internal events
  logic acc, tag_match, acc_fault, acc_hit, acc_miss, store_hit;

  assign idx       = va_q[OFF_W +: IDX_W];
  assign tlb_vpn   = va_q[VA_W-1:PG_W];
  assign acc       = (st_q == S_ACC);
  assign tag_match = vic_valid && (vic_tag == tlb_ppn);
  assign acc_fault = acc && !tlb_hit;
  assign acc_hit   = acc && tlb_hit && tag_match;
  assign acc_miss  = acc && tlb_hit && !tag_match;
  assign store_hit = acc_hit && store_q;

  assign fill_we    = (st_q == S_RFW) && rf_resp_valid;
  assign fill_tag   = fill_addr_q[LADDR_W-1 -: TAG_W];
  assign dirty_set  = store_hit;
  assign data_we    = store_hit || fill_we;
  assign data_wline = fill_we ? rf_resp_data
                              : merge_line(line_rd, va_q[OFF_W-1:0], byte_q, wdata_q);

  assign cpu_req_ready  = (st_q == S_IDLE);
  assign cpu_resp_valid = resp_valid_q;
  assign cpu_resp_fault = resp_fault_q;
  assign cpu_resp_rdata = rdata_q;

  assign wb_valid     = (st_q == S_WB);
  assign wb_addr      = rebuild_line(vic_tag, idx[IN_PG_W-1:0]);
  assign wb_data      = line_rd;
  assign rf_req_valid = (st_q == S_RFQ);
  assign rf_req_addr  = fill_addr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (cpu_req_valid) st_d = S_ACC;
      S_ACC: begin
        if (!tlb_hit || tag_match)      st_d = S_IDLE;
        else if (vic_valid && vic_dirty) st_d = S_WB;
        else                             st_d = S_RFQ;
      end
      S_WB:  if (wb_ready)      st_d = S_RFQ;
      S_RFQ: if (rf_req_ready)  st_d = S_RFW;
      S_RFW: if (rf_resp_valid) st_d = S_ACC;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      va_q         <= '0;
      store_q      <= 1'b0;
      byte_q       <= 1'b0;
      wdata_q      <= '0;
      fill_addr_q  <= '0;
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      rdata_q      <= '0;
    end else begin
      st_q         <= st_d;
      resp_valid_q <= acc_fault || acc_hit;
      resp_fault_q <= acc_fault;
      if (acc_hit && !store_q)
        rdata_q <= read_lane(line_rd, va_q[OFF_W-1:0], byte_q);
      if (acc_miss)
        fill_addr_q <= rebuild_line(tlb_ppn, idx[IN_PG_W-1:0]);
      if (st_q == S_IDLE && cpu_req_valid) begin
        va_q    <= cpu_req_vaddr;
        store_q <= cpu_req_store;
        byte_q  <= cpu_req_byte;
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  // R11: writeback offer holds until taken
  assert_wb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R11: refill request holds until taken
  assert_rf_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !rf_req_ready) |=> (rf_req_valid && $stable(rf_req_addr)));

  // R4: a translation fault ends the access with no next-level traffic
  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |=> (cpu_req_ready && cpu_resp_fault && !wb_valid && !rf_req_valid));

  // R5: the retry after an install hits
  assert_retry_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $past(fill_we)) |-> (tlb_hit && tag_match));

  // R6: only a valid dirty victim is written back
  assert_wb_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (vic_valid && vic_dirty));

  // R7: a clean victim goes straight to refill
  assert_clean_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_miss && !(vic_valid && vic_dirty)) |=> (rf_req_valid && !wb_valid));
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_dcache_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_store,
  input  logic               cpu_req_byte,
  input  logic [VA_W-1:0]    cpu_req_vaddr,
  input  logic [WORD_W-1:0]  cpu_req_wdata,
  output logic               cpu_resp_valid,
  output logic               cpu_resp_fault,
  output logic [WORD_W-1:0]  cpu_resp_rdata,
  output logic [VPN_W-1:0]   tlb_vpn,
  input  logic               tlb_hit,
  input  logic [TAG_W-1:0]   tlb_ppn,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [LADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0]  wb_data,
  output logic               rf_req_valid,
  input  logic               rf_req_ready,
  output logic [LADDR_W-1:0] rf_req_addr,
  input  logic               rf_resp_valid,
  input  logic [LINE_W-1:0]  rf_resp_data
);
  logic [IDX_W-1:0]  idx;
  logic              vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic [LINE_W-1:0] line_rd;
  logic              fill_we, dirty_set, data_we;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] data_wline;

  vipt_dcache_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_store(cpu_req_store), .cpu_req_byte(cpu_req_byte),
    .cpu_req_vaddr(cpu_req_vaddr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_fault(cpu_resp_fault),
    .cpu_resp_rdata(cpu_resp_rdata),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready), .rf_req_addr(rf_req_addr),
    .rf_resp_valid(rf_resp_valid), .rf_resp_data(rf_resp_data),
    .idx(idx), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .line_rd(line_rd), .fill_we(fill_we), .fill_tag(fill_tag),
    .dirty_set(dirty_set), .data_we(data_we), .data_wline(data_wline)
  );

  vipt_dcache_tags u_tags (
    .clk(clk), .rst_n(rst_n), .idx(idx),
    .rd_valid(vic_valid), .rd_dirty(vic_dirty), .rd_tag(vic_tag),
    .fill_we(fill_we), .fill_tag(fill_tag), .dirty_set(dirty_set)
  );

  vipt_dcache_data u_data (
    .clk(clk), .idx(idx), .we(data_we), .wline(data_wline), .rline(line_rd)
  );

  // R1: nothing is offered to the next level in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cpu_req_ready && !cpu_resp_valid && !wb_valid && !rf_req_valid));
endmodule

// File: tb/vipt_dcache_bench.sv
module vipt_dcache_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         cpu_req_valid = 0, cpu_req_store = 0, cpu_req_byte = 0;
  logic [31:0]  cpu_req_vaddr = '0, cpu_req_wdata = '0;
  logic         cpu_req_ready, cpu_resp_valid, cpu_resp_fault;
  logic [31:0]  cpu_resp_rdata;
  logic [19:0]  tlb_vpn, tlb_ppn;
  logic         tlb_hit;
  logic         wb_valid, rf_req_valid;
  logic         wb_ready = 0, rf_req_ready = 0, rf_resp_valid = 0;
  logic [26:0]  wb_addr, rf_req_addr;
  logic [255:0] wb_data, rf_resp_data = '0;

  vipt_dcache u_vipt_dcache (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // ---- TLB model ----
  logic [19:0] map_vpn [5];
  logic [19:0] map_ppn [5];
  initial begin
    map_vpn[0] = 20'h00011; map_ppn[0] = 20'h12340;
    map_vpn[1] = 20'h00023; map_ppn[1] = 20'h12341;
    map_vpn[2] = 20'h00040; map_ppn[2] = 20'h0ABCD;
    map_vpn[3] = 20'h00050; map_ppn[3] = 20'h0ABCE;
    map_vpn[4] = 20'h00077; map_ppn[4] = 20'h00777;
  end
  always_comb begin
    tlb_hit = 1'b0;
    tlb_ppn = '0;
    for (int i = 0; i < 5; i++)
      if (map_vpn[i] == tlb_vpn) begin tlb_hit = 1'b1; tlb_ppn = map_ppn[i]; end
  end

  // ---- next-level memory model ----
  function automatic logic [255:0] pat_line(input logic [26:0] a);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = ({a, 5'b0} + 32'(k * 4)) ^ 32'hC3A5_0F00;
    return r;
  endfunction

  logic [255:0] mem [logic [26:0]];
  function automatic logic [255:0] mem_line(input logic [26:0] a);
    if (mem.exists(a)) return mem[a];
    return pat_line(a);
  endfunction

  int          wb_cnt = 0, rf_cnt = 0, evt = 0, wb_evt = 0, rf_evt = 0;
  int          wb_stall = 0;
  logic [26:0] last_wb_addr, last_rf_addr;
  logic [255:0] last_wb_data;
  bit          rf_pend = 0;
  logic [26:0] rf_pend_addr;

  initial begin
    forever begin
      @(negedge clk);
      wb_ready = 0; rf_req_ready = 0; rf_resp_valid = 0;
      if (wb_valid) begin
        if (wb_stall > 0) wb_stall--;
        else begin
          wb_ready = 1; wb_cnt++; evt++; wb_evt = evt;
          last_wb_addr = wb_addr; last_wb_data = wb_data;
          mem[wb_addr] = wb_data;
        end
      end else if (rf_pend) begin
        rf_resp_valid = 1; rf_resp_data = mem_line(rf_pend_addr); rf_pend = 0;
      end else if (rf_req_valid) begin
        rf_req_ready = 1; rf_cnt++; evt++; rf_evt = evt;
        last_rf_addr = rf_req_addr; rf_pend = 1; rf_pend_addr = rf_req_addr;
      end
    end
  end

  // ---- helpers ----
  task automatic chk(input string req, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit st, input bit byt, input logic [31:0] va,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output bit flt, output int lat);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_store = st; cpu_req_byte = byt;
    cpu_req_vaddr = va; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    lat = 1;
    while (!cpu_resp_valid && lat < 500) begin @(negedge clk); lat++; end
    rd = cpu_resp_rdata; flt = cpu_resp_fault;
  endtask

  function automatic logic [31:0] pword(input logic [26:0] a, input int k);
    logic [255:0] l;
    l = pat_line(a);
    return l[k*32 +: 32];
  endfunction

  // ---- scenarios ----
  task automatic t_reset;
    chk("R1", "req_ready", 256'(cpu_req_ready), 256'(1));
    chk("R1", "resp_valid", 256'(cpu_resp_valid), 256'(0));
    chk("R1", "wb/rf idle", 256'({wb_valid, rf_req_valid}), 256'(0));
  endtask

  task automatic t_load_miss_clean;
    logic [31:0] rd; bit f; int lat; int w0, r0;
    w0 = wb_cnt; r0 = rf_cnt;
    access(0, 0, 32'h0004_0A44, 0, rd, f, lat);
    chk("R5", "refill count", 256'(rf_cnt - r0), 256'(1));
    chk("R5", "refill addr", 256'(last_rf_addr), 256'({20'h0ABCD, 7'h52}));
    chk("R7", "no writeback on empty victim", 256'(wb_cnt - w0), 256'(0));
    chk("R5", "load data", 256'(rd), 256'(pword({20'h0ABCD, 7'h52}, 1)));
    chk("R4", "no fault", 256'(f), 256'(0));
  endtask

  task automatic t_hits_and_stores;
    logic [31:0] rd; bit f; int lat; int r0;
    r0 = rf_cnt;
    access(0, 0, 32'h0004_0A5C, 0, rd, f, lat);
    chk("R2", "hit data word7", 256'(rd), 256'(pword({20'h0ABCD, 7'h52}, 7)));
    chk("R2", "hit latency", 256'(lat), 256'(2));
    access(1, 0, 32'h0004_0A48, 32'hDEAD_BEEF, rd, f, lat);
    chk("R8", "store hit latency", 256'(lat), 256'(2));
    access(0, 1, 32'h0004_0A4B, 0, rd, f, lat);
    chk("R10", "byte load offset 11", 256'(rd), 256'(32'h0000_00DE));
    access(0, 1, 32'h0004_0A48, 0, rd, f, lat);
    chk("R10", "byte load offset 8", 256'(rd), 256'(32'h0000_00EF));
    access(0, 0, 32'h0004_0A4A, 0, rd, f, lat);
    chk("R10", "word load ignores low bits", 256'(rd), 256'(32'hDEAD_BEEF));
    access(1, 1, 32'h0004_0A49, 32'hFFFF_FF5A, rd, f, lat);
    access(0, 0, 32'h0004_0A48, 0, rd, f, lat);
    chk("R8", "byte store merge", 256'(rd), 256'(32'hDEAD_5AEF));
    chk("R8", "no refill for hits", 256'(rf_cnt - r0), 256'(0));
  endtask

  task automatic t_store_allocate;
    logic [31:0] rd; bit f; int lat; int w0, r0;
    w0 = wb_cnt; r0 = rf_cnt;
    access(1, 0, 32'h0001_1040, 32'h1122_3344, rd, f, lat);
    chk("R9", "store miss refill", 256'(rf_cnt - r0), 256'(1));
    chk("R9", "refill addr", 256'(last_rf_addr), 256'({20'h12340, 7'h02}));
    chk("R9", "no writeback", 256'(wb_cnt - w0), 256'(0));
    access(0, 0, 32'h0001_1040, 0, rd, f, lat);
    chk("R9", "stored word", 256'(rd), 256'(32'h1122_3344));
    access(0, 0, 32'h0001_1044, 0, rd, f, lat);
    chk("R9", "untouched word", 256'(rd), 256'(pword({20'h12340, 7'h02}, 1)));
    chk("R2", "hit after allocate", 256'(rf_cnt - r0), 256'(1));
  endtask

  task automatic t_tlb_fault;
    logic [31:0] rd; bit f; int lat; int w0, r0;
    w0 = wb_cnt; r0 = rf_cnt;
    access(0, 0, 32'h0009_9040, 0, rd, f, lat);
    chk("R4", "load fault flag", 256'(f), 256'(1));
    access(1, 0, 32'h0009_9040, 32'h0BAD_0BAD, rd, f, lat);
    chk("R4", "store fault flag", 256'(f), 256'(1));
    chk("R4", "no traffic on fault", 256'({wb_cnt - w0, rf_cnt - r0}), 256'(0));
    access(0, 0, 32'h0001_1040, 0, rd, f, lat);
    chk("R4", "resident line unchanged", 256'(rd), 256'(32'h1122_3344));
    chk("R4", "still a hit", 256'({lat, rf_cnt - r0}), 256'({32'd2, 32'd0}));
  endtask

  task automatic t_conflict_full_tag;
    logic [31:0] rd; bit f; int lat; int w0, r0;
    logic [255:0] exp;
    w0 = wb_cnt; r0 = rf_cnt;
    wb_stall = 3;
    access(0, 0, 32'h0002_3040, 0, rd, f, lat);
    chk("R3", "neighbour page misses", 256'(rf_cnt - r0), 256'(1));
    chk("R6", "dirty victim written", 256'(wb_cnt - w0), 256'(1));
    chk("R6", "writeback addr from tag", 256'(last_wb_addr), 256'({20'h12340, 7'h02}));
    exp = pat_line({20'h12340, 7'h02});
    exp[31:0] = 32'h1122_3344;
    chk("R11", "writeback data after stall", last_wb_data, exp);
    chk("R6", "writeback before refill", 256'(wb_evt < rf_evt), 256'(1));
    chk("R3", "new page data", 256'(rd), 256'(pword({20'h12341, 7'h02}, 0)));
  endtask

  task automatic t_evict_then_clean;
    logic [31:0] rd; bit f; int lat; int w0, r0;
    logic [255:0] exp;
    w0 = wb_cnt;
    access(0, 0, 32'h0005_0A40, 0, rd, f, lat);
    chk("R6", "second writeback addr", 256'(last_wb_addr), 256'({20'h0ABCD, 7'h52}));
    exp = pat_line({20'h0ABCD, 7'h52});
    exp[95:64] = 32'hDEAD_5AEF;
    chk("R6", "second writeback data", last_wb_data, exp);
    chk("R5", "load after evict", 256'(rd), 256'(pword({20'h0ABCE, 7'h52}, 0)));
    w0 = wb_cnt; r0 = rf_cnt;
    access(0, 0, 32'h0004_0A48, 0, rd, f, lat);
    chk("R7", "clean victim no writeback", 256'(wb_cnt - w0), 256'(0));
    chk("R7", "refill after clean victim", 256'(rf_cnt - r0), 256'(1));
    chk("R6", "written-back data refetched", 256'(rd), 256'(32'hDEAD_5AEF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_miss_clean();
    t_hits_and_stores();
    t_store_allocate();
    t_tlb_fault();
    t_conflict_full_tag();
    t_evict_then_clean();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule